// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital half of a 10-bit successive-approximation converter. Software enables it and then sets a start/busy bit in a control register. The sequencer then runs a binary search, most significant bit first, against an external one-bit comparator. It presents one trial code per conversion-clock period (TAD) and stores the finished code in a pair of 8-bit result bytes. The code is placed at the right or left of the byte pair, and the unused bits are filled with zeros. TAD is a programmable division of the system clock.

Clearing the start/busy bit during a search abandons it at once. The result bytes keep their previous contents. The sequencer then idles for exactly two TAD and goes back to sampling the input without any further command. While the converter is disabled, the two result bytes act as plain scratch registers. The analog side is reduced to a trial-code output, a sampling indicator and the comparator input.

Top module: `sar_adc_seq`

## Requirements
- R1: Writing the control register (address 0) with bit 1 (start/busy) at 0 and bit 0 (enable) at 1 during a conversion stops it on that clock edge. After the edge, control bit 1 reads 0 and `trial_code` is 0.
- R2: A stopped conversion leaves the high result byte (address 1) and the low result byte (address 2) unchanged.
- R3: After a stop, `sampling` stays low for exactly 2·(D+1) clock cycles. D is the divider register at address 3 (reset value 3), and one TAD is D+1 system clocks.
- R4: When that wait ends, `sampling` rises by itself. No new start is needed.
- R5: When control bit 2 (format) is 1, completion writes zeros to high-byte bits 7:2, code bits 9:8 to high-byte bits 1:0, and code bits 7:0 to the low byte.
- R6: When the format bit is 0, completion writes code bits 9:2 to the high byte and code bits 1:0 to low-byte bits 7:6. Low-byte bits 5:0 are set to 0.
- R7: While enable is 0, no conversion runs, and addresses 1 and 2 read back whatever was last written to them. Writing 0 to enable stops a conversion that is running.
- R8: A control write that sets enable and start together while enable was 0 sets only enable. The start is ignored.
- R9: The search resolves bits 9 down to 0, one per TAD. During step k, `trial_code` holds the bits already kept plus the trial bit. A trial bit is kept when `cmp_in` is 1, meaning the input is at or above the trial level.
- R10: On completion the result bytes are written, control bit 1 reads 0, and `done` is high for exactly one cycle.
- R11: A conversion lasts exactly 10·(D+1) clock cycles, counted from the start write to `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 control, 1 high byte, 2 low byte, 3 divider |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address, same map as writes |
| rd_data | output | 8 | Read data (combinational) |
| cmp_in | input | 1 | Comparator: 1 when the input is at or above `trial_code` |
| trial_code | output | 10 | Trial level for the comparator, 0 outside a conversion |
| sampling | output | 1 | High while acquiring (enabled, idle) |
| done | output | 1 | One-cycle pulse at conversion completion |

## Verification
Assertions check on every cycle the properties that hold at every clock:
- a stop leaves the result bytes untouched and enters the wait state;
- zero fill is present for the format in use at completion;
- `done` never lasts two cycles;
- a disabled converter stays quiet;
- an enabling write never starts a conversion.

The bench's reference model is compared against the design on every clock and shows the properties that span many cycles:
- the exact trial-code sequence for chosen inputs;
- conversion and wait lengths under different divider settings;
- the automatic return to sampling after a stop;
- the result bytes surviving long idle periods while the converter is disabled.

// File: rtl/sar_adc_seq.sv
module sar_adc_seq #(
  parameter logic [7:0] DIV_RESET = 8'd3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic [1:0] rd_addr,
  output logic [7:0] rd_data,
  input  logic       cmp_in,
  output logic [9:0] trial_code,
  output logic       sampling,
  output logic       done
);
  localparam int RES_W = 10;
  localparam logic [3:0] TOP_BIT = 4'(RES_W - 1);

  typedef enum logic [1:0] {S_OFF = 2'd0, S_ACQ = 2'd1, S_CONV = 2'd2, S_WAIT = 2'd3} state_t;

  state_t           state_q;
  logic [7:0]       div_q, div_cnt, res_hi, res_lo;
  logic             fmt_q, wait_q, done_q;
  logic [3:0]       idx_q;
  logic [RES_W-1:0] code_q, final_code;
  logic             ctrl_wr, tick, abort, start, finish;

  assign ctrl_wr    = wr_en && (wr_addr == 2'd0);
  assign tick       = (div_cnt >= div_q);
  assign abort      = ctrl_wr && (state_q == S_CONV) && !(wr_data[0] && wr_data[1]);
  assign start      = ctrl_wr && (state_q == S_ACQ) && wr_data[0] && wr_data[1];
  assign finish     = (state_q == S_CONV) && tick && (idx_q == 4'd0) && !abort;
  assign final_code = {code_q[RES_W-1:1], cmp_in};

  assign trial_code = (state_q == S_CONV) ? (code_q | (RES_W'(1) << idx_q)) : '0;
  assign sampling   = (state_q == S_ACQ);
  assign done       = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_OFF;
      wait_q  <= 1'b0;
    end else if (ctrl_wr && !wr_data[0]) begin
      state_q <= S_OFF;
    end else if (ctrl_wr && state_q == S_OFF) begin
      state_q <= S_ACQ;
    end else if (abort) begin
      state_q <= S_WAIT;
      wait_q  <= 1'b0;
    end else if (start) begin
      state_q <= S_CONV;
    end else if (finish) begin
      state_q <= S_ACQ;
    end else if (state_q == S_WAIT && tick) begin
      if (wait_q) state_q <= S_ACQ;
      wait_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              div_cnt <= '0;
    else if (abort || start) div_cnt <= '0;
    else if (tick)           div_cnt <= '0;
    else                     div_cnt <= div_cnt + 8'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      idx_q  <= '0;
    end else if (start) begin
      code_q <= '0;
      idx_q  <= TOP_BIT;
    end else if (state_q == S_CONV && tick && !abort) begin
      code_q[idx_q] <= cmp_in;
      idx_q         <= idx_q - 4'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_hi <= '0;
      res_lo <= '0;
      fmt_q  <= 1'b0;
      div_q  <= DIV_RESET;
      done_q <= 1'b0;
    end else begin
      done_q <= finish;
      if (finish) begin
        if (fmt_q) begin
          res_hi <= {6'd0, final_code[9:8]};
          res_lo <= final_code[7:0];
        end else begin
          res_hi <= final_code[9:2];
          res_lo <= {final_code[1:0], 6'd0};
        end
      end else if (wr_en && wr_addr == 2'd1) begin
        res_hi <= wr_data;
      end else if (wr_en && wr_addr == 2'd2) begin
        res_lo <= wr_data;
      end
      if (ctrl_wr) fmt_q <= wr_data[2];
      if (wr_en && wr_addr == 2'd3) div_q <= wr_data;
    end
  end

  always_comb begin
    case (rd_addr)
      2'd0:    rd_data = {5'd0, fmt_q, state_q == S_CONV, state_q != S_OFF};
      2'd1:    rd_data = res_hi;
      2'd2:    rd_data = res_lo;
      default: rd_data = div_q;
    endcase
  end
endmodule

// File: rtl/sar_adc_seq_chk.sv
module sar_adc_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] state,
  input logic       done,
  input logic       fmt,
  input logic [7:0] res_hi,
  input logic [7:0] res_lo,
  input logic       wr_en,
  input logic [1:0] wr_addr,
  input logic [7:0] wr_data,
  input logic [9:0] trial_code
);
  logic ctrl_wr, stop_req;
  assign ctrl_wr  = wr_en && (wr_addr == 2'd0);
  assign stop_req = ctrl_wr && (state == 2'd2) && wr_data[0] && !wr_data[1];

  p_stop_now_r1: assert property (@(posedge clk) disable iff (!rst_n)
    stop_req |=> (state == 2'd3) && (trial_code == 10'd0));

  p_stop_keeps_result_r2: assert property (@(posedge clk) disable iff (!rst_n)
    stop_req |=> $stable(res_hi) && $stable(res_lo));

  p_right_fill_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(fmt)) |-> (res_hi[7:2] == 6'd0));

  p_left_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !$past(fmt)) |-> (res_lo[5:0] == 6'd0));

  p_off_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 2'd0) |-> (!done && trial_code == 10'd0));

  p_no_start_on_enable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && state == 2'd0) |=> (state != 2'd2));

  p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind sar_adc_seq sar_adc_seq_chk chk (
  .clk(clk), .rst_n(rst_n), .state(state_q), .done(done_q), .fmt(fmt_q),
  .res_hi(res_hi), .res_lo(res_lo), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .trial_code(trial_code)
);

// File: tb/sar_adc_seq_test.sv
module sar_adc_seq_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = 2'd0;
  logic [1:0] rd_addr = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic [7:0] rd_data;
  logic       cmp_in;
  logic [9:0] trial_code;
  logic       sampling, done;
  logic [9:0] vin = 10'd0;

  always #5 clk = ~clk;

  assign cmp_in = (vin >= trial_code);

  sar_adc_seq uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .cmp_in(cmp_in), .trial_code(trial_code),
    .sampling(sampling), .done(done)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Behavioural reference: 0 off, 1 sampling, 2 converting, 3 waiting
  int m_state, m_cnt, m_hi, m_lo, m_fmt, m_div, m_done, m_p;
  bit m_cw, m_fin;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_state = 0; m_cnt = 0; m_hi = 0; m_lo = 0; m_fmt = 0; m_div = 3; m_done = 0;
    end else begin
      m_cw = wr_en && wr_addr == 2'd0;
      m_p = m_div + 1;
      m_fin = 1'b0;
      m_done = 0;
      if (m_cw && !wr_data[0]) m_state = 0;
      else if (m_cw && m_state == 0) m_state = 1;
      else if (m_cw && m_state == 2 && !wr_data[1]) begin m_state = 3; m_cnt = 0; end
      else if (m_cw && m_state == 1 && wr_data[1]) begin m_state = 2; m_cnt = 0; end
      else if (m_state == 2) begin
        m_cnt++;
        if (m_cnt == 10 * m_p) begin m_state = 1; m_fin = 1'b1; end
      end else if (m_state == 3) begin
        m_cnt++;
        if (m_cnt == 2 * m_p) m_state = 1;
      end
      if (m_fin) begin
        m_done = 1;
        if (m_fmt != 0) begin m_hi = int'(vin) >> 8; m_lo = int'(vin) & 255; end
        else begin m_hi = int'(vin) >> 2; m_lo = (int'(vin) & 3) << 6; end
      end else if (wr_en && wr_addr == 2'd1) m_hi = int'(wr_data);
      else if (wr_en && wr_addr == 2'd2) m_lo = int'(wr_data);
      if (m_cw) m_fmt = int'(wr_data[2]);
      if (wr_en && wr_addr == 2'd3) m_div = int'(wr_data);
    end
  end

  function automatic int exp_trial();
    int k, sh;
    if (m_state != 2) return 0;
    k = m_cnt / (m_div + 1);
    sh = 10 - k;
    return ((int'(vin) >> sh) << sh) | (1 << (9 - k));
  endfunction

  function automatic int exp_rd(input logic [1:0] a);
    case (a)
      2'd0: return (m_fmt << 2) | ((m_state == 2) << 1) | int'(m_state != 0);
      2'd1: return m_hi;
      2'd2: return m_lo;
      default: return m_div;
    endcase
  endfunction

  always @(posedge clk) begin
    #2;
    if (rst_n && !finished) begin
      chk("R9 trial_code per cycle", int'(trial_code), exp_trial());
      chk("R4 sampling per cycle", int'(sampling), int'(m_state == 1));
      chk("R10 done per cycle", int'(done), m_done);
      chk("R7 rd_data per cycle", int'(rd_data), exp_rd(rd_addr));
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    rd_addr = a;
    #1;
    v = int'(rd_data);
  endtask

  task automatic wait_done(output int n);
    n = 0;
    while (!done && n < 5000) begin @(negedge clk); n++; end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    int v, n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd(2'd0, v); chk("R7 reset control", v, 0);
    rd(2'd1, v); chk("R7 reset high byte", v, 0);

    // R7: disabled bytes are scratch registers
    wr(2'd1, 8'hA5); wr(2'd2, 8'h5A);
    rd(2'd1, v); chk("R7 high byte rw", v, 8'hA5);
    rd(2'd2, v); chk("R7 low byte rw", v, 8'h5A);

    // R8: enable and start together
    vin = 10'h2C7;
    wr(2'd0, 8'h03);
    rd(2'd0, v); chk("R8 start ignored on enable", v, 8'h01);
    repeat (50) @(negedge clk);
    rd(2'd1, v); chk("R8 no conversion after enable", v, 8'hA5);

    // R5/R10/R11 right-justified conversion, D=3
    wr(2'd0, 8'h07); wait_done(n);
    chk("R11 conversion length D=3", n, 40);
    rd(2'd1, v); chk("R5 right high byte", v, 8'h02);
    rd(2'd2, v); chk("R5 right low byte", v, 8'hC7);
    rd(2'd0, v); chk("R10 busy cleared", v, 8'h05);
    @(negedge clk); chk("R10 done single cycle", int'(done), 0);

    // R6 left-justified
    wr(2'd0, 8'h03); wait_done(n);
    rd(2'd1, v); chk("R6 left high byte", v, 8'hB1);
    rd(2'd2, v); chk("R6 left low byte", v, 8'hC0);

    // R1-style stop mid-conversion, then R2, R3, R4
    vin = 10'h155;
    wr(2'd0, 8'h07);
    repeat (13) @(negedge clk);
    wr(2'd0, 8'h05);
    rd(2'd0, v); chk("R1 busy clears on stop", v, 8'h05);
    chk("R1 trial code zero after stop", int'(trial_code), 0);
    n = 0;
    while (!sampling && n < 5000) begin @(negedge clk); n++; end
    chk("R3 stop wait length", n, 8);
    chk("R4 sampling resumes on its own", int'(sampling), 1);
    rd(2'd1, v); chk("R2 high byte kept", v, 8'hB1);
    rd(2'd2, v); chk("R2 low byte kept", v, 8'hC0);

    // R11/R9 divider 0, full-scale and zero inputs
    wr(2'd3, 8'd0);
    vin = 10'h3FF;
    wr(2'd0, 8'h07); wait_done(n);
    chk("R11 conversion length D=0", n, 10);
    rd(2'd1, v); chk("R9 full scale high", v, 8'h03);
    rd(2'd2, v); chk("R9 full scale low", v, 8'hFF);
    vin = 10'h000;
    wr(2'd0, 8'h07); wait_done(n);
    rd(2'd1, v); chk("R9 zero high", v, 0);
    rd(2'd2, v); chk("R9 zero low", v, 0);

    // R3 with D=1: wait is 4 cycles
    wr(2'd3, 8'd1);
    vin = 10'h2AA;
    wr(2'd0, 8'h07);
    repeat (5) @(negedge clk);
    wr(2'd0, 8'h05);
    n = 0;
    while (!sampling && n < 5000) begin @(negedge clk); n++; end
    chk("R3 stop wait length D=1", n, 4);

    // R7: disabling mid-conversion, then scratch use
    wr(2'd0, 8'h07);
    repeat (5) @(negedge clk);
    wr(2'd0, 8'h00);
    rd(2'd0, v); chk("R7 disable stops conversion", v, 0);
    wr(2'd1, 8'h3C);
    repeat (60) @(negedge clk);
    rd(2'd1, v); chk("R7 byte not overwritten while off", v, 8'h3C);
    rd(2'd2, v); chk("R7 low byte kept while off", v, 0);

    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog expired actual running expected finished");
      summary();
      $finish;
    end
  end
endmodule